// File: doc/BRIEF.md
# Dual-Processor Interleaved Bank Memory Arbiter

This block connects two processors to a shared memory of 32 interleaved banks. The banks sit on four lines of eight banks each. Each processor has four request ports: two vector load ports, one vector store port and one I/O port. Port `l` of a processor always talks to line `l`, so the four ports of one processor never compete with each other. Every line takes at most one request per cycle. A bank that has taken a request stays busy for four cycles. When the two processors want the same line, an alternating arbiter picks the winner and the other request waits.

Each port uses a valid/ready handshake. `req_ready` is combinational: it rises in the same cycle that the request is granted. A read returns its word on the port's response strobe a fixed four cycles after the handshake. A write updates the bank's storage at the grant edge and produces no response. Each bank has a small storage array, cleared by reset, so the data path can be checked from end to end. The global bank number is `{bank-in-line, line}`, with the line implied by the port.

Top module: `ilv_bank_arbiter`

## Requirements
- R1: Port `i` is processor `i/4`, line `i%4`. Its 6-bit address field is `req_addr[6*i +: 6]`. Bits [2:0] pick the bank within the line and bits [5:3] pick the word within that bank, so distinct banks or words hold independent data.
- R2: A valid request whose target bank is free, with no competing eligible request on its line, sees `req_ready` high in that same cycle. `req_ready` is never high without `req_valid`.
- R3: After a bank is granted in cycle k, no request to that bank is granted in cycles k+1 to k+3. A waiting request to it is granted in cycle k+4.
- R4: Different banks of one line can be granted in consecutive cycles.
- R5: At most one of the two ports on a line is granted in any cycle.
- R6: When both processors have eligible requests on one line, the processor not granted last on that line wins. Priority toggles after every grant on the line, and processor 0 is favoured after reset.
- R7: A request stalled on a busy bank does not stop the other processor's request to a free bank on the same line from being granted, even when the stalled processor holds priority.
- R8: The lines are independent. All four ports of one processor can be granted in the same cycle.
- R9: A granted read raises `rsp_valid[i]` for exactly one cycle, four cycles after the handshake cycle. `rsp_data[16*i +: 16]` then carries the word stored at the grant.
- R10: A granted write stores `req_wdata[16*i +: 16]` at the grant edge. A later read from any port on that line returns it, and the write raises no response.
- R11: Reset clears all bank timers, all responses, the storage (reads return 0) and the priority (processor 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 8 | Request valid, one per port |
| req_write | input | 8 | 1 = write, 0 = read, per port |
| req_addr | input | 48 | Per-port {word[2:0], bank[2:0]} |
| req_wdata | input | 128 | Per-port 16-bit write data |
| req_ready | output | 8 | Grant, same cycle as valid |
| rsp_valid | output | 8 | Read data strobe, per port |
| rsp_data | output | 128 | Per-port 16-bit read data |

## Verification
Two checks can fall in the same cycle: line arbitration between the two processors, and the bank-busy interval. This happens when a losing or favoured request targets a bank that is still counting down. Directed sequences build exactly that case: the favoured processor is stalled on a busy bank while the other asks for a free one, and contention on a line is held over several cycles. Random traffic limited to four banks per line makes both conditions common. A bench model of the busy timers, the line priority and the storage then judges every ready bit and every response cycle by cycle.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  // Two-way winner selection for one line: favour1 picks processor 1 on a tie.
  function automatic logic [1:0] pick_winner(input logic [1:0] elig, input logic favour1);
    if (elig == 2'b11) return favour1 ? 2'b10 : 2'b01;
    return elig;
  endfunction
endpackage

// File: rtl/ilv_rsp_pipe.sv
module ilv_rsp_pipe #(
  parameter int LAT = 4,
  parameter int DW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_fire,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  logic [LAT-1:0] vq;
  logic [DW-1:0]  dq [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) vq <= '0;
    else begin
      vq[0] <= in_fire;
      for (int i = 1; i < LAT; i++) vq[i] <= vq[i-1];
    end
  end

  always_ff @(posedge clk) begin
    dq[0] <= in_data;
    for (int i = 1; i < LAT; i++) dq[i] <= dq[i-1];
  end

  assign out_valid = vq[LAT-1];
  assign out_data  = dq[LAT-1];

  assert_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);
endmodule

// File: rtl/ilv_line.sv
module ilv_line #(
  parameter int NB   = 8,
  parameter int WA   = 3,
  parameter int DW   = 16,
  parameter int BUSY = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              vld,
  input  logic [1:0]              wr,
  input  logic [2*$clog2(NB)-1:0] bsel,
  input  logic [2*WA-1:0]         widx,
  input  logic [2*DW-1:0]         wdat,
  output logic [1:0]              gnt,
  output logic [2*DW-1:0]         rdat,
  output logic [NB-1:0]           bank_busy
);
  localparam int BW    = $clog2(NB);
  localparam int CW    = $clog2(BUSY + 1);
  localparam int WORDS = 1 << WA;

  function automatic logic [CW-1:0] tick(input logic [CW-1:0] c, input logic hit);
    if (hit) return CW'(BUSY - 1);
    if (c != '0) return c - CW'(1);
    return c;
  endfunction

  logic [BW-1:0] b0, b1;
  logic [WA-1:0] w0, w1;
  logic [1:0]    elig;
  logic          favour1;
  logic [NB-1:0] hit;
  logic [DW-1:0] rd0 [NB];
  logic [DW-1:0] rd1 [NB];

  assign b0 = bsel[BW-1:0];
  assign b1 = bsel[2*BW-1:BW];
  assign w0 = widx[WA-1:0];
  assign w1 = widx[2*WA-1:WA];

  assign elig[0] = vld[0] && !bank_busy[b0];
  assign elig[1] = vld[1] && !bank_busy[b1];
  assign gnt     = ilv_pkg::pick_winner(elig, favour1);

  always_ff @(posedge clk) begin
    if (!rst_n) favour1 <= 1'b0;
    else if (gnt != 2'b00) favour1 <= gnt[0];
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [CW-1:0] cnt;
    logic [DW-1:0] store [WORDS];
    logic          we0, we1;

    assign hit[b] = (gnt[0] && b0 == BW'(b)) || (gnt[1] && b1 == BW'(b));
    assign bank_busy[b] = (cnt != '0);
    assign we0 = gnt[0] && wr[0] && b0 == BW'(b);
    assign we1 = gnt[1] && wr[1] && b1 == BW'(b);

    always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= tick(cnt, hit[b]);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int w = 0; w < WORDS; w++) store[w] <= '0;
      end else if (we0) begin
        store[w0] <= wdat[DW-1:0];
      end else if (we1) begin
        store[w1] <= wdat[2*DW-1:DW];
      end
    end

    assign rd0[b] = store[w0];
    assign rd1[b] = store[w1];

    assert_bank_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit[b] |=> (bank_busy[b] && !hit[b]));
  end

  assign rdat = {rd1[b1], rd0[b0]};

  assert_one_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~vld) == 2'b00);
  assert_alternate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (elig == 2'b11 && gnt[0]) ##1 (elig == 2'b11) |-> gnt[1]);
endmodule

// File: rtl/ilv_bank_arbiter.sv
module ilv_bank_arbiter #(
  parameter int N_LINE = 4,
  parameter int NBL    = 8,
  parameter int WA     = 3,
  parameter int DW     = 16,
  parameter int BUSY   = 4,
  parameter int RD_LAT = 4
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic [2*N_LINE-1:0]                        req_valid,
  input  logic [2*N_LINE-1:0]                        req_write,
  input  logic [2*N_LINE*($clog2(NBL)+WA)-1:0]       req_addr,
  input  logic [2*N_LINE*DW-1:0]                     req_wdata,
  output logic [2*N_LINE-1:0]                        req_ready,
  output logic [2*N_LINE-1:0]                        rsp_valid,
  output logic [2*N_LINE*DW-1:0]                     rsp_data
);
  localparam int BW   = $clog2(NBL);
  localparam int PA_W = BW + WA;

  function automatic logic [BW-1:0] bank_of(input logic [PA_W-1:0] a);
    return a[BW-1:0];
  endfunction

  function automatic logic [WA-1:0] word_of(input logic [PA_W-1:0] a);
    return a[PA_W-1:BW];
  endfunction

  for (genvar l = 0; l < N_LINE; l++) begin : g_line
    localparam int P0 = l;
    localparam int P1 = N_LINE + l;
    logic [PA_W-1:0] a0, a1;
    logic [1:0]      g;
    logic [2*DW-1:0] rd;
    logic [NBL-1:0]  busy;

    assign a0 = req_addr[P0*PA_W +: PA_W];
    assign a1 = req_addr[P1*PA_W +: PA_W];

    ilv_line #(.NB(NBL), .WA(WA), .DW(DW), .BUSY(BUSY)) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .vld      ({req_valid[P1], req_valid[P0]}),
      .wr       ({req_write[P1], req_write[P0]}),
      .bsel     ({bank_of(a1), bank_of(a0)}),
      .widx     ({word_of(a1), word_of(a0)}),
      .wdat     ({req_wdata[P1*DW +: DW], req_wdata[P0*DW +: DW]}),
      .gnt      (g),
      .rdat     (rd),
      .bank_busy(busy)
    );

    assign req_ready[P0] = g[0];
    assign req_ready[P1] = g[1];

    for (genvar c = 0; c < 2; c++) begin : g_port
      localparam int P = c * N_LINE + l;
      ilv_rsp_pipe #(.LAT(RD_LAT), .DW(DW)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_fire  (g[c] && !req_write[P]),
        .in_data  (rd[c*DW +: DW]),
        .out_valid(rsp_valid[P]),
        .out_data (rsp_data[P*DW +: DW])
      );
    end

    assert_line_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_ready[P0] && req_ready[P1]));
    assert_ready_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready[P0] |-> !busy[bank_of(a0)]);
  end
endmodule

// File: tb/sim_ilv_bank_arbiter.sv
module sim_ilv_bank_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]   req_valid = '0, req_write = '0;
  logic [47:0]  req_addr = '0;
  logic [127:0] req_wdata = '0;
  logic [7:0]   req_ready, rsp_valid;
  logic [127:0] rsp_data;

  ilv_bank_arbiter u0 (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] s_v = '0, s_w = '0;
  logic [47:0] s_a = '0;
  logic [127:0] s_d = '0;
  logic [7:0] got_rdy, got_rv;
  logic [127:0] got_rd;

  int busy_m [32];
  bit prio_m [4];
  logic [15:0] mem_m [32][8];
  bit ev [8][4];
  logic [15:0] ed [8][4];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int gbank(input int p);
    return int'(s_a[p*6 +: 3]) * 4 + (p % 4);
  endfunction

  function automatic logic [7:0] model_grants();
    logic [7:0] g = '0;
    for (int l = 0; l < 4; l++) begin
      bit e0 = s_v[l] && busy_m[gbank(l)] == 0;
      bit e1 = s_v[4+l] && busy_m[gbank(4+l)] == 0;
      if (e0 && e1) g[prio_m[l] ? 4+l : l] = 1'b1;
      else if (e0) g[l] = 1'b1;
      else if (e1) g[4+l] = 1'b1;
    end
    return g;
  endfunction

  task automatic model_update(input logic [7:0] g);
    for (int p = 0; p < 8; p++) begin
      for (int k = 3; k > 0; k--) begin ev[p][k] = ev[p][k-1]; ed[p][k] = ed[p][k-1]; end
      ev[p][0] = 0;
    end
    for (int b = 0; b < 32; b++) if (busy_m[b] > 0) busy_m[b]--;
    for (int p = 0; p < 8; p++) if (g[p]) begin
      int gb = gbank(p);
      int wd = int'(s_a[p*6+3 +: 3]);
      busy_m[gb] = 3;
      prio_m[p%4] = (p < 4);
      if (s_w[p]) mem_m[gb][wd] = s_d[p*16 +: 16];
      else begin ev[p][0] = 1; ed[p][0] = mem_m[gb][wd]; end
    end
  endtask

  task automatic cycle();
    logic [7:0] eg;
    @(negedge clk);
    req_valid = s_v; req_write = s_w; req_addr = s_a; req_wdata = s_d;
    #1;
    eg = model_grants();
    got_rdy = req_ready; got_rv = rsp_valid; got_rd = rsp_data;
    for (int p = 0; p < 8; p++) chk(got_rdy[p] == eg[p], "R2 ready", got_rdy, eg);
    for (int l = 0; l < 4; l++) chk(!(got_rdy[l] && got_rdy[4+l]), "R5 one per line", got_rdy, 0);
    for (int p = 0; p < 8; p++) begin
      chk(got_rv[p] == ev[p][3], "R9 rsp valid", got_rv, p);
      if (ev[p][3]) chk(got_rd[p*16 +: 16] == ed[p][3], "R9 rsp data", got_rd[p*16 +: 16], ed[p][3]);
    end
    @(posedge clk);
    model_update(eg);
  endtask

  task automatic clr();
    s_v = '0; s_w = '0;
  endtask

  task automatic put(input int p, input bit w, input int bank, input int word, input logic [15:0] d);
    s_v[p] = 1'b1; s_w[p] = w;
    s_a[p*6 +: 6] = {3'(word), 3'(bank)};
    s_d[p*16 +: 16] = d;
  endtask

  task automatic idle(input int n);
    clr();
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int b = 0; b < 32; b++) begin
      busy_m[b] = 0;
      for (int w = 0; w < 8; w++) mem_m[b][w] = '0;
    end
    for (int l = 0; l < 4; l++) prio_m[l] = 0;
    for (int p = 0; p < 8; p++) for (int k = 0; k < 4; k++) begin ev[p][k] = 0; ed[p][k] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R11: quiet after reset, storage cleared
    idle(1);
    chk(got_rdy == 0 && got_rv == 0, "R11 reset outputs", {got_rdy, got_rv}, 0);
    put(0, 0, 1, 2, 0); cycle();
    chk(got_rdy[0], "R2 lone request granted", got_rdy, 1);
    idle(4);
    chk(got_rv[0] && got_rd[15:0] == 0, "R11 cleared storage read", got_rd[15:0], 0);

    // line0 priority now favours processor 1; R3/R10
    clr(); put(4, 1, 2, 6, 16'hBEEF); put(0, 0, 2, 6, 0); cycle();
    chk(got_rdy[4] && !got_rdy[0], "R6 favoured processor 1", got_rdy, 8'h10);
    clr(); put(0, 0, 2, 6, 0);
    for (int i = 1; i <= 3; i++) begin
      cycle();
      chk(!got_rdy[0], "R3 bank still busy", got_rdy, 0);
    end
    cycle();
    chk(got_rdy[0], "R3 bank free after four cycles", got_rdy, 1);
    chk(!got_rv[4], "R10 no response for write", got_rv, 0);
    idle(4);
    chk(got_rv[0] && got_rd[15:0] == 16'hBEEF, "R10 written word read back", got_rd[15:0], 16'hBEEF);

    // R1: neighbouring word and neighbouring bank are independent
    clr(); put(0, 0, 2, 5, 0); cycle(); idle(4);
    chk(got_rv[0] && got_rd[15:0] == 0, "R1 other word in bank", got_rd[15:0], 0);
    clr(); put(0, 0, 3, 6, 0); cycle(); idle(4);
    chk(got_rv[0] && got_rd[15:0] == 0, "R1 other bank in line", got_rd[15:0], 0);

    // R6 alternation on line1
    clr(); put(1, 0, 0, 0, 0); put(5, 0, 1, 0, 0); cycle();
    chk(got_rdy[1] && !got_rdy[5], "R6 first tie to processor 0", got_rdy, 8'h02);
    clr(); put(1, 0, 2, 0, 0); put(5, 0, 1, 0, 0); cycle();
    chk(got_rdy[5] && !got_rdy[1], "R6 second tie to processor 1", got_rdy, 8'h20);
    clr(); put(1, 0, 2, 0, 0); put(5, 0, 3, 0, 0); cycle();
    chk(got_rdy[1] && !got_rdy[5], "R6 third tie to processor 0", got_rdy, 8'h02);
    idle(4);

    // R7 on line2: favoured processor 0 stalled on busy bank
    clr(); put(6, 0, 5, 0, 0); cycle();
    clr(); put(2, 0, 5, 0, 0); put(6, 0, 6, 0, 0); cycle();
    chk(got_rdy[6] && !got_rdy[2], "R7 free bank wins over stalled", got_rdy, 8'h40);
    idle(4);

    // R4 on line3
    clr(); put(3, 0, 0, 0, 0); cycle();
    chk(got_rdy[3], "R4 first bank", got_rdy, 8'h08);
    clr(); put(3, 0, 1, 0, 0); cycle();
    chk(got_rdy[3], "R4 next bank next cycle", got_rdy, 8'h08);
    idle(4);

    // R8: all four ports of processor 0 together
    clr(); for (int p = 0; p < 4; p++) put(p, 0, 7, 0, 0); cycle();
    chk(got_rdy == 8'h0F, "R8 four lines at once", got_rdy, 8'h0F);
    idle(4);

    // random traffic, narrow bank range to force conflicts
    for (int i = 0; i < 4000; i++) begin
      clr();
      for (int p = 0; p < 8; p++)
        if ($urandom_range(1, 0) == 1)
          put(p, $urandom_range(9, 0) < 3, $urandom_range(3, 0), $urandom_range(7, 0), 16'($urandom));
      cycle();
    end
    idle(6);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule